// File: doc/BRIEF.md
# Programmable-Rate CIC Interpolator

This block raises the sample rate of a stream by an integer factor R. The factor is chosen at run time from 8 to 2048. It uses only adders, subtractors and registers. Four differentiator sections run at the slow input rate, each with a differential delay of one sample. The result is zero-stuffed by R, and four accumulator sections then run at the fast output rate on every clock. In an upconversion chain it is the high-factor stage that follows the FIR interpolators.

The block paces its source. It raises `in_req` for one cycle every R clocks and takes exactly one sample per request, marked with `in_valid` in that same cycle. An output word is produced on every clock. The DC gain of the structure is R^3. A programmable arithmetic right shift brings the output back to a usable scale for each rate. The accumulators use a width of input width + 4·log2(2048) − 3 bits and wrap in two's complement. Rate and shift are loaded with a one-cycle `cfg_load` strobe. That strobe also clears every stored value, so a new rate never mixes with old filter state.

Top module: `cic_interp`

## Requirements
- R1: While `rst` is high and for the one cycle after it or after `cfg_load`, `out_valid` is low. In every other cycle it is high. Reset selects R = 8 and shift 0 and leaves `out_data` at 0.
- R2: `in_req` is high in the first cycle after reset or load, then for exactly one cycle in every R cycles.
- R3: A sample accepted in cycle k (`in_valid` high in that cycle) contributes x·h[n] to the internal sum seen in cycle k+5+n. Here h[n] is the coefficient of z^-n in (1 + z^-1 + … + z^-(R-1))^4. Contributions of successive samples, placed R cycles apart, add.
- R4: A constant input A reaches a steady internal sum of A·R^3. With shift log2(R^3) the output equals A.
- R5: `out_data` is the low 24 bits of the internal sum arithmetically shifted right by the loaded shift amount.
- R6: A loaded rate below 8 acts as 8. A loaded rate above 2048 acts as 2048.
- R7: `cfg_load` clears all differentiator and accumulator state, so `out_data` is 0 in the cycle after the load.
- R8: Cycles with `in_valid` low feed zero into the accumulators, and `in_data` has no effect in them.
- R9: At R = 2048, a full-scale input of −32768 passes through with no overflow. With shift 33 it settles to exactly −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load rate and shift, clear filter state |
| cfg_rate | input | 12 | Requested interpolation factor |
| cfg_shift | input | 6 | Output right-shift amount |
| in_req | output | 1 | Request for the next input sample |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output word valid |
| out_data | output | 24 | Signed, scaled output sample |

## Verification
The bench builds the block with its default parameters: 16-bit input, 24-bit output, four stages and rates 8 to 2048. This keeps the full 57-bit accumulator in play. It runs every output cycle of impulse and step responses at R = 8, at the odd factor 13 and at the maximum 2048. Each is compared against a closed-form count of h[n], so both the smallest and the widest growth are covered sample by sample. Clamped rate requests, mid-run reloads and random data on idle cycles come within reach at the same time.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
package cic_pkg;

    localparam int CIC_IN_W     = 16;
    localparam int CIC_OUT_W    = 24;
    localparam int CIC_STAGES   = 4;
    localparam int CIC_RATE_MIN = 8;
    localparam int CIC_RATE_MAX = 2048;

    // Accumulator width: input + stages*log2(Rmax) - (stages-1)
    function automatic int cic_acc_width(int in_w, int stages, int rate_max);
        return in_w + stages * $clog2(rate_max) - (stages - 1);
    endfunction

    // Bits needed to hold the largest rate value itself
    function automatic int cic_rate_width(int rate_max);
        return $clog2(rate_max + 1);
    endfunction

endpackage

// File: rtl/cic_rate_ctrl.sv
`timescale 1ns/1ps
module cic_rate_ctrl #(
    parameter int RATE_MIN = 8,
    parameter int RATE_MAX = 2048,
    parameter int RATE_W   = 12,
    parameter int SHIFT_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_load,
    input  logic [RATE_W-1:0]  cfg_rate,
    input  logic [SHIFT_W-1:0] cfg_shift,
    output logic [SHIFT_W-1:0] shift_q,
    output logic               in_req,
    output logic               flush
);

    localparam logic [RATE_W-1:0] LO = RATE_W'(RATE_MIN);
    localparam logic [RATE_W-1:0] HI = RATE_W'(RATE_MAX);

    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] rate_sel;
    logic [RATE_W-1:0] phase_q;

    assign flush = rst | cfg_load;

    always_comb begin
        if (cfg_rate < LO)      rate_sel = LO;
        else if (cfg_rate > HI) rate_sel = HI;
        else                    rate_sel = cfg_rate;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q  <= LO;
            shift_q <= '0;
        end else if (cfg_load) begin
            rate_q  <= rate_sel;
            shift_q <= cfg_shift;
        end
    end

    always_ff @(posedge clk) begin
        if (flush)                       phase_q <= '0;
        else if (phase_q == rate_q - 1'b1) phase_q <= '0;
        else                             phase_q <= phase_q + 1'b1;
    end

    assign in_req = (phase_q == '0);

    // Checker: cycles elapsed since the previous request
    logic [RATE_W:0] gap_q;
    logic            seen_q;
    always_ff @(posedge clk) begin
        if (flush) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (in_req) begin
            gap_q  <= 1;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    AST_REQ_SPACING: assert property (@(posedge clk) disable iff (rst)
        (in_req && seen_q && !cfg_load) |-> (gap_q == {1'b0, rate_q}))
        else $error("request spacing differs from rate"); // R2

    AST_RATE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (rate_q >= LO) && (rate_q <= HI))
        else $error("rate outside legal range"); // R6

    AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(rate_q))
        else $error("rate changed without a load"); // R7

endmodule

// File: rtl/cic_comb_chain.sv
`timescale 1ns/1ps
module cic_comb_chain #(
    parameter int W      = 57,
    parameter int STAGES = 4
) (
    input  logic                clk,
    input  logic                flush,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_data,
    output logic signed [W-1:0] comb_q
);

    logic signed [W-1:0] dly_q [STAGES];
    logic signed [W-1:0] diff  [STAGES+1];

    assign diff[0] = in_data;

    for (genvar i = 0; i < STAGES; i++) begin : g_comb
        assign diff[i+1] = diff[i] - dly_q[i];
        always_ff @(posedge clk) begin
            if (flush)         dly_q[i] <= '0;
            else if (in_valid) dly_q[i] <= diff[i];
        end
    end

    always_ff @(posedge clk) begin
        if (flush)         comb_q <= '0;
        else if (in_valid) comb_q <= diff[STAGES];
    end

    AST_COMB_HOLD: assert property (@(posedge clk) disable iff (flush)
        !in_valid |=> $stable(comb_q))
        else $error("differentiator moved without a sample"); // R8

endmodule

// File: rtl/cic_integ_chain.sv
`timescale 1ns/1ps
module cic_integ_chain #(
    parameter int W       = 57,
    parameter int STAGES  = 4,
    parameter int OUT_W   = 24,
    parameter int SHIFT_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                in_valid,
    input  logic signed [W-1:0] comb_in,
    input  logic [SHIFT_W-1:0]  shift,
    output logic [OUT_W-1:0]    out_data
);

    logic                stuff_q;
    logic signed [W-1:0] acc_q [STAGES];
    logic signed [W-1:0] feed  [STAGES];

    // Zero-stuffing: the new differentiator result enters once per sample
    always_ff @(posedge clk) begin
        if (flush) stuff_q <= 1'b0;
        else       stuff_q <= in_valid;
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_integ
        if (i == 0) begin : g_head
            assign feed[i] = stuff_q ? comb_in : '0;
        end else begin : g_tail
            assign feed[i] = acc_q[i-1];
        end
        always_ff @(posedge clk) begin
            if (flush) acc_q[i] <= '0;
            else       acc_q[i] <= acc_q[i] + feed[i];
        end
    end

    assign out_data = OUT_W'(acc_q[STAGES-1] >>> shift);

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (acc_q[STAGES-1] == '0) && (acc_q[0] == '0))
        else $error("accumulators not cleared by load"); // R7

    AST_IDLE_NO_FEED: assert property (@(posedge clk) disable iff (flush)
        !stuff_q |=> $stable(acc_q[0]))
        else $error("first accumulator moved on a stuffed zero"); // R8

endmodule

// File: rtl/cic_interp.sv
`timescale 1ns/1ps
module cic_interp
    import cic_pkg::*;
#(
    parameter  int IN_W     = CIC_IN_W,
    parameter  int OUT_W    = CIC_OUT_W,
    parameter  int STAGES   = CIC_STAGES,
    parameter  int RATE_MIN = CIC_RATE_MIN,
    parameter  int RATE_MAX = CIC_RATE_MAX,
    localparam int RATE_W   = cic_rate_width(RATE_MAX),
    localparam int ACC_W    = cic_acc_width(IN_W, STAGES, RATE_MAX),
    localparam int SHIFT_W  = $clog2(ACC_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_load,
    input  logic [RATE_W-1:0]  cfg_rate,
    input  logic [SHIFT_W-1:0] cfg_shift,
    output logic               in_req,
    input  logic               in_valid,
    input  logic [IN_W-1:0]    in_data,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data
);

    localparam int EXT_W = ACC_W - IN_W;

    logic                    flush;
    logic [SHIFT_W-1:0]      shift_q;
    logic signed [ACC_W-1:0] in_ext;
    logic signed [ACC_W-1:0] comb_q;

    assign in_ext = {{EXT_W{in_data[IN_W-1]}}, in_data};

    cic_rate_ctrl #(
        .RATE_MIN(RATE_MIN), .RATE_MAX(RATE_MAX),
        .RATE_W(RATE_W), .SHIFT_W(SHIFT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .cfg_load(cfg_load),
        .cfg_rate(cfg_rate), .cfg_shift(cfg_shift),
        .shift_q(shift_q), .in_req(in_req), .flush(flush)
    );

    cic_comb_chain #(.W(ACC_W), .STAGES(STAGES)) u_comb (
        .clk(clk), .flush(flush), .in_valid(in_valid),
        .in_data(in_ext), .comb_q(comb_q)
    );

    cic_integ_chain #(
        .W(ACC_W), .STAGES(STAGES), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)
    ) u_integ (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
        .comb_in(comb_q), .shift(shift_q), .out_data(out_data)
    );

    always_ff @(posedge clk) begin
        out_valid <= !flush;
    end

endmodule

// File: tb/tb_cic_interp.sv
`timescale 1ns/1ps
module tb_cic_interp;

    localparam int IN_W    = 16;
    localparam int OUT_W   = 24;
    localparam int RATE_W  = 12;
    localparam int SHIFT_W = 6;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_load = 1'b0;
    logic [RATE_W-1:0]  cfg_rate = '0;
    logic [SHIFT_W-1:0] cfg_shift = '0;
    logic               in_req;
    logic               in_valid = 1'b0;
    logic [IN_W-1:0]    in_data = '0;
    logic               out_valid;
    logic [OUT_W-1:0]   out_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cic_interp dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_rate(cfg_rate),
        .cfg_shift(cfg_shift), .in_req(in_req), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    // Number of ways to place t items into 4 bins: C(t+3,3)
    function automatic longint c3(longint t);
        if (t < 0) return 0;
        return (t + 3) * (t + 2) * (t + 1) / 6;
    endfunction

    // Coefficient of z^-n in (1 + ... + z^-(r-1))^4
    function automatic longint h_of(longint n, longint r);
        if (n < 0) return 0;
        return c3(n) - 4 * c3(n - r) + 6 * c3(n - 2 * r)
               - 4 * c3(n - 3 * r) + c3(n - 4 * r);
    endfunction

    function automatic longint y_of(longint n, longint r, bit step);
        longint acc = 0;
        if (n < 0) return 0;
        if (!step) return h_of(n, r);
        for (longint m = 0; m * r <= n; m++) acc += h_of(n - m * r, r);
        return acc;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Load a configuration and run one response, checking every output cycle
    task automatic run_resp(int req_rate, int eff_rate, int shift, bit step,
                            int amp, int ncyc, string tag);
        @(negedge clk);
        cfg_load  = 1'b1;
        cfg_rate  = RATE_W'(req_rate);
        cfg_shift = SHIFT_W'(shift);
        in_valid  = 1'b0;
        @(negedge clk);
        cfg_load = 1'b0;
        // R7: state cleared right after the load
        check(out_data == '0, "R7 flush", longint'(out_data), 0);
        for (int k = 0; k < ncyc; k++) begin
            longint e;
            logic [63:0] ev;
            bit exp_req;
            e  = longint'(amp) * y_of(k - 5, eff_rate, step);
            ev = 64'(e >>> shift);
            check(out_data == ev[OUT_W-1:0], tag,
                  longint'($signed(out_data)), longint'($signed(ev[OUT_W-1:0])));
            exp_req = (k % eff_rate) == 0;
            check(in_req == exp_req, (req_rate != eff_rate) ? "R6 clamp" : "R2 req",
                  longint'(in_req), longint'(exp_req));
            check(out_valid == (k != 0), "R1 out_valid",
                  longint'(out_valid), longint'(k != 0));
            if (exp_req) begin
                in_valid = 1'b1;
                in_data  = (step || k == 0) ? IN_W'(amp) : '0;
            end else begin
                in_valid = 1'b0;
                in_data  = IN_W'($urandom);  // R8: ignored
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(in_req == 1'b1, "R1 req", longint'(in_req), 1);
        check(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
        check(out_data == '0, "R1 out", longint'(out_data), 0);
        for (int j = 1; j < 25; j++) begin
            @(negedge clk);
            check(in_req == ((j % 8) == 0), "R1 default rate", longint'(in_req),
                  longint'((j % 8) == 0));
            check(out_valid == 1'b1, "R1 out_valid", longint'(out_valid), 1);
            check(out_data == '0, "R1 out", longint'(out_data), 0);
        end

        run_resp(8,    8,    0,  1'b0, 1000,   50,   "R3 impulse R8x");
        run_resp(13,   13,   0,  1'b0, -777,   70,   "R8 impulse odd rate");
        run_resp(8,    8,    9,  1'b1, 300,    80,   "R4 step");
        run_resp(3,    8,    9,  1'b1, -5000,  60,   "R6 step clamped");
        run_resp(4000, 2048, 12, 1'b0, 32767,  4 * 2048 + 12, "R5 impulse max");
        run_resp(2048, 2048, 33, 1'b1, -32768, 4 * 2048 + 40, "R9 step full scale");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule